// File: doc/BRIEF.md
# Dual-Host GPIO Controller with Per-Pin Ownership

This block drives and senses up to 32 general purpose pins for two bus masters. A single set of pin state (output value, direction, interrupt polarity, interrupt mask, interrupt flag, input mirror, pin enable and owner) is kept once. Each master reaches that state through its own register window. The privileged master sees every pin and also controls the pin-enable and owner registers. The secondary master sees only the pins whose owner bit is set.

Each master has a simple single-cycle bus. Reads are combinational within the access cycle, and writes take effect at the next clock edge. Pad inputs are synchronised before they reach any register or interrupt logic. Each pin raises a level-sensitive flag. Each master has its own interrupt line, covering the unmasked flags of the pins it owns.

Top module: `sgpio_dual`

## Requirements
- R1: After reset, every register reads 0 in both windows, `pad_oe` is 0 and both interrupt outputs are 0.
- R2: Privileged window offsets: pin enable 0x1C, output 0x20, direction 0x24, input 0x28, polarity 0x2C, flag 0x30, mask 0x34, mirror 0x38, owner 0x3C. The enable, output, direction, polarity, mask and owner registers read back the value written last.
- R3: Secondary window offsets: output 0x00, direction 0x04, input 0x08, polarity 0x0C, flag 0x10, mask 0x14, mirror 0x18. Every secondary read returns the shared value ANDed with the owner register, so bits of unowned pins read 0.
- R4: A secondary write changes only bits of owned pins. Secondary accesses at offsets 0x1C and above read 0 and change nothing, so the enable and owner registers cannot be reached from the secondary window.
- R5: Setting an owner bit moves no data. A value the privileged master wrote earlier is visible in the secondary window in the cycle after the owner write.
- R6: `pad_out` equals the output register, and `pad_oe` equals direction AND pin enable, per bit.
- R7: A pad input value appears in the input register after two clock edges, through a two-flop synchroniser. A pin whose enable bit is 0 reads 0 in the input and mirror registers.
- R8: The mirror register holds the value the input register had one cycle earlier.
- R9: A flag bit sets at the edge after the synchronised input of an enabled pin equals its polarity bit (1 = high active, 0 = low active). Once set, it stays set until it is cleared.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If the condition still holds, the flag sets again at the next edge. A secondary write clears only owned flag bits.
- R11: `s_irq` is the OR of flag AND mask AND owner. `p_irq` is the OR of flag AND mask AND NOT owner.
- R12: When both masters write the same register in the same cycle, the privileged write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_sel | input | 1 | Privileged bus access strobe |
| p_wr | input | 1 | Privileged write (1) or read (0) |
| p_addr | input | 6 | Privileged byte offset |
| p_wdata | input | NPINS | Privileged write data |
| p_rdata | output | NPINS | Privileged read data, valid in the access cycle |
| s_sel | input | 1 | Secondary bus access strobe |
| s_wr | input | 1 | Secondary write (1) or read (0) |
| s_addr | input | 6 | Secondary byte offset |
| s_wdata | input | NPINS | Secondary write data |
| s_rdata | output | NPINS | Secondary read data, masked by owner |
| pad_in | input | NPINS | Raw pad inputs |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| p_irq | output | 1 | Interrupt for the privileged master |
| s_irq | output | 1 | Interrupt for the secondary master |

## Verification
The hardest case to reach is a flag clear that lands while the pin condition still holds. The cleared state lasts for a single cycle, so it is only visible to a read placed in the gap between the clearing edge and the next one.

The bench sets up this case directly. It steers a pin through the synchroniser into a held condition, issues the clear, and reads the flag at once and again one edge later. The same timing separates a secondary clear of an unowned flag from a real clear.

Randomised traffic from both masters, with random owner masks, covers the masking of reads and writes.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;

   typedef enum logic [3:0] {
      RG_OUT, RG_DIR, RG_IN, RG_LVL, RG_FLAG, RG_MASK, RG_MIR, RG_EN, RG_OWN, RG_NONE
   } sgpio_reg_e;

   // Map a word index (offset / 4) inside a seven-register window.
   function automatic sgpio_reg_e window_reg(input logic [3:0] idx);
      case (idx)
         4'd0:    return RG_OUT;
         4'd1:    return RG_DIR;
         4'd2:    return RG_IN;
         4'd3:    return RG_LVL;
         4'd4:    return RG_FLAG;
         4'd5:    return RG_MASK;
         4'd6:    return RG_MIR;
         default: return RG_NONE;
      endcase
   endfunction

   // Secondary window: word 0..6.
   function automatic sgpio_reg_e decode_sec(input logic [5:0] addr);
      if (addr[1:0] != 2'b00) return RG_NONE;
      return window_reg(addr[5:2]);
   endfunction

   // Privileged window: enable at word 7, common set at 8..14, owner at 15.
   function automatic sgpio_reg_e decode_pri(input logic [5:0] addr);
      if (addr[1:0] != 2'b00) return RG_NONE;
      case (addr[5:2])
         4'd7:    return RG_EN;
         4'd15:   return RG_OWN;
         default: return (addr[5:2] >= 4'd8) ? window_reg(addr[5:2] - 4'd8) : RG_NONE;
      endcase
   endfunction

endpackage

// File: rtl/sgpio_sync.sv
module sgpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sgpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)      chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else             chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sgpio_flags.sv
module sgpio_flags #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] in_sync,
   input  logic [W-1:0] level,
   input  logic [W-1:0] enable,
   input  logic [W-1:0] clr,
   output logic [W-1:0] flag
);
   logic [W-1:0] hit;

   // A pin matches when it is enabled and its input equals its polarity bit.
   assign hit = enable & ~(in_sync ^ level);

   always_ff @(posedge clk) begin
      if (!rst_n) flag <= '0;
      else        flag <= (flag | hit) & ~clr;
   end

   assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag & $past(hit & ~clr)) == $past(hit & ~clr)));

   assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag & $past(flag & ~clr)) == $past(flag & ~clr)));

   assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr != '0) |=> ((flag & $past(clr)) == '0));
endmodule

// File: rtl/sgpio_dual.sv
module sgpio_dual
   import sgpio_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             p_sel,
   input  logic             p_wr,
   input  logic [ADDR_W-1:0] p_addr,
   input  logic [NPINS-1:0] p_wdata,
   output logic [NPINS-1:0] p_rdata,
   input  logic             s_sel,
   input  logic             s_wr,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [NPINS-1:0] s_wdata,
   output logic [NPINS-1:0] s_rdata,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   output logic             p_irq,
   output logic             s_irq
);
   localparam int W = NPINS;

   if (NPINS < 1 || NPINS > 32) begin : g_bad_pins
      $error("sgpio_dual: NPINS must be 1..32");
   end
   if (ADDR_W != 6) begin : g_bad_addr
      $error("sgpio_dual: ADDR_W must be 6");
   end

   logic [W-1:0] out_q, dir_q, lvl_q, mask_q, en_q, own_q, mir_q;
   logic [W-1:0] sync_in, in_g, flag, clr;
   sgpio_reg_e   p_kind, s_kind;
   logic         p_we, s_we;

   assign p_kind = decode_pri(p_addr);
   assign s_kind = decode_sec(s_addr);
   assign p_we   = p_sel & p_wr;
   assign s_we   = s_sel & s_wr;

   // Next value of a shared register: secondary touches owned bits, privileged overrides.
   function automatic logic [W-1:0] merge(input logic [W-1:0] cur,
                                          input sgpio_reg_e  kind);
      logic [W-1:0] v;
      v = cur;
      if (s_we && s_kind == kind) v = (v & ~own_q) | (s_wdata & own_q);
      if (p_we && p_kind == kind) v = p_wdata;
      return v;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         lvl_q  <= '0;
         mask_q <= '0;
         en_q   <= '0;
         own_q  <= '0;
         mir_q  <= '0;
      end else begin
         out_q  <= merge(out_q, RG_OUT);
         dir_q  <= merge(dir_q, RG_DIR);
         lvl_q  <= merge(lvl_q, RG_LVL);
         mask_q <= merge(mask_q, RG_MASK);
         en_q   <= (p_we && p_kind == RG_EN)  ? p_wdata : en_q;
         own_q  <= (p_we && p_kind == RG_OWN) ? p_wdata : own_q;
         mir_q  <= in_g;
      end
   end

   sgpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (sync_in)
   );

   assign in_g = sync_in & en_q;

   assign clr = ((p_we && p_kind == RG_FLAG) ? p_wdata : '0)
              | ((s_we && s_kind == RG_FLAG) ? (s_wdata & own_q) : '0);

   sgpio_flags #(.W(W)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_sync(sync_in),
      .level  (lvl_q),
      .enable (en_q),
      .clr    (clr),
      .flag   (flag)
   );

   function automatic logic [W-1:0] view(input sgpio_reg_e kind);
      case (kind)
         RG_OUT:  return out_q;
         RG_DIR:  return dir_q;
         RG_IN:   return in_g;
         RG_LVL:  return lvl_q;
         RG_FLAG: return flag;
         RG_MASK: return mask_q;
         RG_MIR:  return mir_q;
         RG_EN:   return en_q;
         RG_OWN:  return own_q;
         default: return '0;
      endcase
   endfunction

   assign p_rdata = p_sel ? view(p_kind) : '0;
   assign s_rdata = s_sel ? (view(s_kind) & own_q) : '0;

   assign pad_out = out_q;
   assign pad_oe  = dir_q & en_q;
   assign p_irq   = |(flag & mask_q & ~own_q);
   assign s_irq   = |(flag & mask_q & own_q);

   assert_mirror_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (mir_q == $past(in_g)));

   assert_sec_no_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!p_we) |=> ($stable(own_q) && $stable(en_q)));

   assert_sec_owned_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!p_we) |=> (((out_q ^ $past(out_q)) & ~$past(own_q)) == '0));
endmodule

// File: tb/sgpio_dual_test.sv
module sgpio_dual_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        p_sel = 0, p_wr = 0, s_sel = 0, s_wr = 0;
   logic [5:0]  p_addr = 0, s_addr = 0;
   logic [31:0] p_wdata = 0, s_wdata = 0, pad_in = 0;
   logic [31:0] p_rdata, s_rdata, pad_out, pad_oe;
   logic        p_irq, s_irq;

   int n_chk = 0, n_bad = 0;
   logic [31:0] m_out = 0, m_dir = 0, m_lvl = 0, m_mask = 0, m_en = 0, m_own = 0;

   always #5 clk = ~clk;

   sgpio_dual uut (
      .clk(clk), .rst_n(rst_n),
      .p_sel(p_sel), .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
      .s_sel(s_sel), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .p_irq(p_irq), .s_irq(s_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // One bus cycle on either or both hosts; returns at the negedge after the write edge.
   task automatic bus(input logic pv, input logic [5:0] pa, input logic [31:0] pd,
                      input logic sv, input logic [5:0] sa, input logic [31:0] sd);
      @(negedge clk);
      p_sel = pv; p_wr = pv; p_addr = pa; p_wdata = pd;
      s_sel = sv; s_wr = sv; s_addr = sa; s_wdata = sd;
      @(negedge clk);
      p_sel = 0; p_wr = 0; s_sel = 0; s_wr = 0;
   endtask

   task automatic pw(input logic [5:0] a, input logic [31:0] d);
      bus(1'b1, a, d, 1'b0, 6'h0, 32'h0);
   endtask

   task automatic sw(input logic [5:0] a, input logic [31:0] d);
      bus(1'b0, 6'h0, 32'h0, 1'b1, a, d);
   endtask

   task automatic prd(input logic [5:0] a, output logic [31:0] d);
      p_sel = 1; p_wr = 0; p_addr = a; #1; d = p_rdata; p_sel = 0;
   endtask

   task automatic srd(input logic [5:0] a, output logic [31:0] d);
      s_sel = 1; s_wr = 0; s_addr = a; #1; d = s_rdata; s_sel = 0;
   endtask

   // Model of the read/write store, seen from either window.
   function automatic logic [31:0] mget(input bit sec, input logic [5:0] a);
      logic [31:0] v;
      if (sec) begin
         case (a)
            6'h00: v = m_out;  6'h04: v = m_dir;
            6'h0C: v = m_lvl;  6'h14: v = m_mask;
            default: v = 0;
         endcase
         return v & m_own;
      end
      case (a)
         6'h1C: v = m_en;   6'h20: v = m_out; 6'h24: v = m_dir;
         6'h2C: v = m_lvl;  6'h34: v = m_mask; 6'h3C: v = m_own;
         default: v = 0;
      endcase
      return v;
   endfunction

   function automatic logic [31:0] mix(input bit sec, input logic [31:0] cur, input logic [31:0] d);
      return sec ? ((cur & ~m_own) | (d & m_own)) : d;
   endfunction

   task automatic mset(input bit sec, input logic [5:0] a, input logic [31:0] d);
      if (sec) begin
         case (a)
            6'h00: m_out  = mix(1, m_out, d);
            6'h04: m_dir  = mix(1, m_dir, d);
            6'h0C: m_lvl  = mix(1, m_lvl, d);
            6'h14: m_mask = mix(1, m_mask, d);
            default: ;
         endcase
      end else begin
         case (a)
            6'h1C: m_en = d;   6'h20: m_out = d;  6'h24: m_dir = d;
            6'h2C: m_lvl = d;  6'h34: m_mask = d; 6'h3C: m_own = d;
            default: ;
         endcase
      end
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [5:0]  pa [6];
      logic [5:0]  sa [4];
      void'($urandom(32'd20240611));
      pa[0] = 6'h1C; pa[1] = 6'h20; pa[2] = 6'h24; pa[3] = 6'h2C; pa[4] = 6'h34; pa[5] = 6'h3C;
      sa[0] = 6'h00; sa[1] = 6'h04; sa[2] = 6'h0C; sa[3] = 6'h14;

      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      for (int a = 0; a < 64; a += 4) begin
         prd(a[5:0], r); chk("R1 priv reg", r, 0);
         srd(a[5:0], r); chk("R1 sec reg", r, 0);
      end
      chk("R1 pad_oe", pad_oe, 0);
      chk("R1 irqs", {30'd0, p_irq, s_irq}, 0);

      // R6 pad drive
      pw(6'h1C, 32'hFFFF_FFFF);
      pw(6'h24, 32'h0000_0F0F);
      pw(6'h20, 32'hA5A5_A5A5);
      chk("R6 pad_out", pad_out, 32'hA5A5_A5A5);
      chk("R6 pad_oe", pad_oe, 32'h0000_0F0F);
      pw(6'h1C, 32'h0000_00FF);
      chk("R6 pad_oe gated by enable", pad_oe, 32'h0000_000F);
      pw(6'h1C, 32'hFFFF_FFFF);

      // R7 synchroniser depth, R8 mirror lag
      pad_in = 32'h1234_5678;
      tick(1); prd(6'h28, r); chk("R7 input after one edge", r, 0);
      tick(1); prd(6'h28, r); chk("R7 input after two edges", r, 32'h1234_5678);
      prd(6'h38, r); chk("R8 mirror lags", r, 0);
      tick(1); prd(6'h38, r); chk("R8 mirror after lag", r, 32'h1234_5678);
      pw(6'h1C, 32'h0000_FFFF);
      prd(6'h28, r); chk("R7 disabled pins read 0", r, 32'h0000_5678);
      tick(1); prd(6'h38, r); chk("R7 disabled pins mirror 0", r, 32'h0000_5678);
      pw(6'h1C, 32'hFFFF_FFFF);

      // R3 / R5 shared store and owner masking
      pw(6'h20, 32'hAAAA_5555);
      srd(6'h00, r); chk("R3 unowned reads 0", r, 0);
      pw(6'h3C, 32'h0000_FFFF);
      srd(6'h00, r); chk("R5 data visible after owner set", r, 32'h0000_5555);
      srd(6'h08, r); chk("R3 sec input masked", r, 32'h0000_5678);

      // R4 secondary writes limited to owned pins and its own window
      sw(6'h00, 32'hFFFF_FFFF);
      prd(6'h20, r); chk("R4 sec write owned only", r, 32'hAAAA_FFFF);
      sw(6'h3C, 32'hFFFF_FFFF);
      sw(6'h1C, 32'h0);
      prd(6'h3C, r); chk("R4 owner unreachable", r, 32'h0000_FFFF);
      prd(6'h1C, r); chk("R4 enable unreachable", r, 32'hFFFF_FFFF);
      srd(6'h3C, r); chk("R4 sec high offset reads 0", r, 0);

      // R9 / R10 / R11 flags
      pw(6'h3C, 32'h0);
      pw(6'h2C, 32'hFFFF_FFFF);
      pad_in = 32'h0;
      tick(3);
      pw(6'h30, 32'hFFFF_FFFF);
      prd(6'h30, r); chk("R9 no flag without match", r, 0);
      pad_in = 32'h1;
      tick(2); prd(6'h30, r); chk("R9 not yet set", r, 0);
      tick(1); prd(6'h30, r); chk("R9 high active set", r, 32'h1);
      pw(6'h2C, 32'hFFFF_FFFD);
      tick(1); prd(6'h30, r); chk("R9 low active set", r, 32'h3);
      pw(6'h30, 32'h1);
      prd(6'h30, r); chk("R10 clear takes effect", r, 32'h2);
      tick(1); prd(6'h30, r); chk("R10 sets again while held", r, 32'h3);
      pw(6'h30, 32'h0);
      prd(6'h30, r); chk("R10 zero write no effect", r, 32'h3);
      pw(6'h34, 32'h1);
      chk("R11 p_irq", p_irq, 1);
      chk("R11 s_irq", s_irq, 0);
      pw(6'h3C, 32'h1);
      chk("R11 p_irq after owner", p_irq, 0);
      chk("R11 s_irq after owner", s_irq, 1);
      srd(6'h10, r); chk("R3 sec flag masked", r, 32'h1);
      sw(6'h10, 32'h2);
      prd(6'h30, r); chk("R10 sec clear unowned ignored", r, 32'h3);
      sw(6'h10, 32'h1);
      prd(6'h30, r); chk("R10 sec clear owned", r, 32'h2);
      pad_in = 32'h0;
      tick(3);
      pw(6'h30, 32'h1);
      tick(1); prd(6'h30, r); chk("R9 stays clear after release", r & 32'h1, 0);

      // R12 simultaneous writes
      pw(6'h3C, 32'h0000_FFFF);
      bus(1'b1, 6'h20, 32'h1111_1111, 1'b1, 6'h00, 32'h0000_2222);
      prd(6'h20, r); chk("R12 privileged wins", r, 32'h1111_1111);

      // R2 / R3 / R4 random traffic against the model
      m_out = 32'h1111_1111; m_dir = 32'h0000_0F0F; m_lvl = 32'hFFFF_FFFD;
      m_mask = 32'h1; m_en = 32'hFFFF_FFFF; m_own = 32'h0000_FFFF;
      for (int i = 0; i < 300; i++) begin
         bit sec;
         logic [5:0] a;
         logic [31:0] d;
         sec = $urandom_range(0, 1) == 1;
         d = $urandom;
         a = sec ? sa[$urandom_range(0, 3)] : pa[$urandom_range(0, 5)];
         if (sec) sw(a, d); else pw(a, d);
         mset(sec, a, d);
         sec = $urandom_range(0, 1) == 1;
         a = sec ? sa[$urandom_range(0, 3)] : pa[$urandom_range(0, 5)];
         if (sec) begin srd(a, r); chk("R3 random sec read", r, mget(1, a)); end
         else begin prd(a, r); chk("R2 random priv read", r, mget(0, a)); end
         if (i % 50 == 0) chk("R6 random pad_oe", pad_oe, m_dir & m_en);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule